// File: doc/BRIEF.md
# Soft-Rights Page Fault Classifier

This block holds a small table of page entries for a virtual-memory scheme in which the hardware keeps no referenced or dirty bits. Each entry carries three fields: the rights the translation hardware enforces, a second copy of the rights the page is really allowed, and a frame number. Whether a page was used recently, or written since it was loaded, is shown only by how the enforced rights compare with the real rights.

A caller presents a page number with a read or write flag. One cycle later the block returns a one-hot fault class and the frame number of the entry. In the same clock edge it applies the matching repair. When the real rights allow an access that the enforced rights refuse, the fault is soft: the real rights are copied into the enforced field and no paging takes place. The fault is hard when neither field allows any access. It is an access violation when the real rights refuse the operation. An inconsistent entry is reported as an error.

A replacement engine uses the demote port to strip the enforced rights of a page while keeping its real rights. A loader uses the install port to write all three fields of an entry after it brings a page in or evicts one. Choosing a victim and moving data are done elsewhere.

Top module: `pgc_top`

## Requirements
- R1: After reset every entry has real rights none, enforced rights none and frame 0; `resp_valid` is 0 and `resp_class` is 0.
- R2: A request with `acc_valid` high gives `resp_valid` high on the following cycle. `resp_class` is one-hot with bit 0 = no fault, bit 1 = soft, bit 2 = hard, bit 3 = violation and bit 4 = error. `resp_frame` is the frame the entry held before that edge. Without a request, `resp_valid` and `resp_class` are 0 on the following cycle.
- R3: If the enforced rights allow the operation and the entry is consistent, the class is no fault and the entry is left unchanged.
- R4: If the enforced rights refuse the operation and the real rights allow it, the class is soft and the enforced field takes the value of the real field.
- R5: If the enforced rights refuse the operation and the real rights are none, the class is hard and the entry is left unchanged.
- R6: If the enforced rights grant read or write that the real rights do not grant, the class is error, whatever the operation. The entry is left unchanged. This check comes before all the others.
- R7: A write to a page whose real rights allow reading but not writing is a violation, whatever the enforced rights are (unless R6 applies). The entry is left unchanged.
- R8: A demote request sets the enforced rights of the selected entry to none and leaves its real rights and its frame unchanged.
- R9: A clean page has real rights read-write and enforced rights read-only. A read of it is no fault. The first write is soft and makes the enforced rights read-write (the page is now dirty). Later writes are no fault.
- R10: An access and a demote to the same entry in the same cycle are classified on the entry as it was before that edge. The demote is applied after the access repair, so the enforced rights end as none.
- R11: An install writes the real rights, the enforced rights and the frame. It takes effect after any access repair or demote to the same entry in the same cycle, and the access in that cycle is classified on the old contents.
- R12: Rights codes are 2'b00 none, 2'b01 read-only, 2'b10 read-write and 2'b11 read-write. Any nonzero code allows reading, and bit 1 allows writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request |
| acc_page | input | PAGE_W | Page of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| dem_valid | input | 1 | Demote request |
| dem_page | input | PAGE_W | Page to demote |
| inst_valid | input | 1 | Install request |
| inst_page | input | PAGE_W | Page to install |
| inst_soft | input | 2 | Real rights to write |
| inst_hw | input | 2 | Enforced rights to write |
| inst_frame | input | FRAME_W | Frame to write |
| resp_valid | output | 1 | Response present |
| resp_class | output | 5 | One-hot fault class |
| resp_frame | output | FRAME_W | Frame of the accessed entry |

## Verification
The embedded properties assume that page numbers stay below the table depth. They also assume that a demote or repair check on an entry is not disturbed by an install to the same entry in the same cycle, and the properties exclude those collisions explicitly. The directed part of the stimulus drives every relation between real and enforced rights, including both illegal ones and the 2'b11 code. It also collides an access with a demote and with an install on one entry. A pseudo-random phase then mixes all three ports over a small set of pages, using only legal page numbers, so that collisions occur often.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef logic [1:0] rights_t;

  localparam rights_t RT_NONE = 2'b00;
  localparam rights_t RT_RO   = 2'b01;
  localparam rights_t RT_RW   = 2'b10;

  localparam int CLS_W     = 5;
  localparam int CLS_OK    = 0;
  localparam int CLS_SOFT  = 1;
  localparam int CLS_HARD  = 2;
  localparam int CLS_VIOL  = 3;
  localparam int CLS_ERR   = 4;

  function automatic logic may_read(input rights_t r);
    return |r;
  endfunction

  function automatic logic may_write(input rights_t r);
    return r[1];
  endfunction
endpackage

// File: rtl/pgc_classify.sv
module pgc_classify
  import pgc_pkg::*;
(
  input  rights_t                soft_r,
  input  rights_t                hw_r,
  input  logic                   is_write,
  output logic [CLS_W-1:0]       cls,
  output logic                   repair
);
  logic hw_ok, soft_ok, bad;

  always_comb begin
    bad     = (may_read(hw_r) & ~may_read(soft_r)) |
              (may_write(hw_r) & ~may_write(soft_r));
    hw_ok   = is_write ? may_write(hw_r)   : may_read(hw_r);
    soft_ok = is_write ? may_write(soft_r) : may_read(soft_r);
    cls     = '0;
    repair  = 1'b0;
    if (bad)                    cls[CLS_ERR]  = 1'b1;
    else if (hw_ok)             cls[CLS_OK]   = 1'b1;
    else if (soft_ok) begin
      cls[CLS_SOFT] = 1'b1;
      repair        = 1'b1;
    end
    else if (!may_read(soft_r)) cls[CLS_HARD] = 1'b1;
    else                        cls[CLS_VIOL] = 1'b1;
  end
endmodule

// File: rtl/pgc_store.sv
module pgc_store
  import pgc_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int FRAME_W   = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PAGE_W-1:0]  rd_page,
  output rights_t            rd_soft,
  output rights_t            rd_hw,
  output logic [FRAME_W-1:0] rd_frame,
  input  logic               rep_en,
  input  logic [PAGE_W-1:0]  rep_page,
  input  logic               dem_en,
  input  logic [PAGE_W-1:0]  dem_page,
  input  logic               ins_en,
  input  logic [PAGE_W-1:0]  ins_page,
  input  rights_t            ins_soft,
  input  rights_t            ins_hw,
  input  logic [FRAME_W-1:0] ins_frame
);
  rights_t            soft_a [NUM_PAGES];
  rights_t            hw_a   [NUM_PAGES];
  logic [FRAME_W-1:0] frm_a  [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
    rights_t            s_q, s_d, h_q, h_d;
    logic [FRAME_W-1:0] f_q, f_d;
    logic               en;
    logic               hit_rep, hit_dem, hit_ins;

    always_comb begin
      hit_rep = rep_en && (rep_page == PAGE_W'(g));
      hit_dem = dem_en && (dem_page == PAGE_W'(g));
      hit_ins = ins_en && (ins_page == PAGE_W'(g));
      en  = hit_rep | hit_dem | hit_ins;
      s_d = s_q;
      h_d = h_q;
      f_d = f_q;
      if (hit_rep) h_d = s_q;
      if (hit_dem) h_d = RT_NONE;
      if (hit_ins) begin
        s_d = ins_soft;
        h_d = ins_hw;
        f_d = ins_frame;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= RT_NONE;
        h_q <= RT_NONE;
        f_q <= '0;
      end else if (en) begin
        s_q <= s_d;
        h_q <= h_d;
        f_q <= f_d;
      end
    end

    assign soft_a[g] = s_q;
    assign hw_a[g]   = h_q;
    assign frm_a[g]  = f_q;
  end

  assign rd_soft  = soft_a[rd_page];
  assign rd_hw    = hw_a[rd_page];
  assign rd_frame = frm_a[rd_page];

  // Delayed copies of requests, used only by the properties below
  logic               dem_d, dem_clean_d, rep_d, rep_clean_d;
  logic [PAGE_W-1:0]  dem_pg_d, rep_pg_d;
  rights_t            dem_soft_d, rep_soft_d;
  logic [FRAME_W-1:0] dem_frm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dem_d <= 1'b0; dem_clean_d <= 1'b0; rep_d <= 1'b0; rep_clean_d <= 1'b0;
      dem_pg_d <= '0; rep_pg_d <= '0; dem_soft_d <= RT_NONE;
      rep_soft_d <= RT_NONE; dem_frm_d <= '0;
    end else begin
      dem_d       <= dem_en;
      dem_clean_d <= !(ins_en && ins_page == dem_page);
      dem_pg_d    <= dem_page;
      dem_soft_d  <= soft_a[dem_page];
      dem_frm_d   <= frm_a[dem_page];
      rep_d       <= rep_en;
      rep_clean_d <= !(ins_en && ins_page == rep_page) &&
                     !(dem_en && dem_page == rep_page);
      rep_pg_d    <= rep_page;
      rep_soft_d  <= soft_a[rep_page];
    end
  end

  assert_demote_hw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_d && dem_clean_d) |-> hw_a[dem_pg_d] == RT_NONE);
  assert_demote_keeps_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_d && dem_clean_d) |-> (soft_a[dem_pg_d] == dem_soft_d &&
                                frm_a[dem_pg_d] == dem_frm_d));
  assert_repair_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_d && rep_clean_d) |-> hw_a[rep_pg_d] == rep_soft_d);
endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int FRAME_W   = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [PAGE_W-1:0]  acc_page,
  input  logic               acc_write,
  input  logic               dem_valid,
  input  logic [PAGE_W-1:0]  dem_page,
  input  logic               inst_valid,
  input  logic [PAGE_W-1:0]  inst_page,
  input  logic [1:0]         inst_soft,
  input  logic [1:0]         inst_hw,
  input  logic [FRAME_W-1:0] inst_frame,
  output logic               resp_valid,
  output logic [CLS_W-1:0]   resp_class,
  output logic [FRAME_W-1:0] resp_frame
);
  rights_t            cur_soft, cur_hw;
  logic [FRAME_W-1:0] cur_frame;
  logic [CLS_W-1:0]   cls;
  logic               repair;

  pgc_store #(.NUM_PAGES(NUM_PAGES), .FRAME_W(FRAME_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_page(acc_page), .rd_soft(cur_soft), .rd_hw(cur_hw), .rd_frame(cur_frame),
    .rep_en(acc_valid & repair), .rep_page(acc_page),
    .dem_en(dem_valid), .dem_page(dem_page),
    .ins_en(inst_valid), .ins_page(inst_page),
    .ins_soft(inst_soft), .ins_hw(inst_hw), .ins_frame(inst_frame)
  );

  pgc_classify class_i (
    .soft_r(cur_soft), .hw_r(cur_hw), .is_write(acc_write),
    .cls(cls), .repair(repair)
  );

  logic               vld_d;
  logic [CLS_W-1:0]   cls_d;

  always_comb begin
    vld_d = acc_valid;
    cls_d = acc_valid ? cls : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_class <= '0;
      resp_frame <= '0;
    end else begin
      resp_valid <= vld_d;
      resp_class <= cls_d;
      if (acc_valid) resp_frame <= cur_frame;
    end
  end

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!resp_valid && resp_class == '0));
  assert_class_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot(resp_class));
  assert_clean_entry_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_soft == cur_hw && cur_hw == RT_RW) |=> resp_class[CLS_OK]);
  assert_empty_entry_hard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_soft == RT_NONE && cur_hw == RT_NONE) |=> resp_class[CLS_HARD]);
endmodule

// File: tb/pgc_top_tb_top.sv
module pgc_top_tb_top;
  localparam int NP = 16;
  localparam int FW = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, dem_valid = 0, inst_valid = 0;
  logic [PW-1:0] acc_page = '0, dem_page = '0, inst_page = '0;
  logic [1:0] inst_soft = '0, inst_hw = '0;
  logic [FW-1:0] inst_frame = '0;
  logic resp_valid;
  logic [4:0] resp_class;
  logic [FW-1:0] resp_frame;

  always #2 clk = ~clk;

  pgc_top #(.NUM_PAGES(NP), .FRAME_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
    .acc_write(acc_write), .dem_valid(dem_valid), .dem_page(dem_page),
    .inst_valid(inst_valid), .inst_page(inst_page), .inst_soft(inst_soft),
    .inst_hw(inst_hw), .inst_frame(inst_frame), .resp_valid(resp_valid),
    .resp_class(resp_class), .resp_frame(resp_frame)
  );

  int checks = 0, fails = 0;
  int m_soft [NP];
  int m_hw   [NP];
  int m_frm  [NP];
  bit exp_v; int exp_cls; int exp_frm;

  // Class codes follow R2: 1 ok, 2 soft, 4 hard, 8 violation, 16 error
  function automatic int ref_class(int s, int h, bit w);
    bit hr = (h != 0), hwr = (h >= 2), sr = (s != 0), swr = (s >= 2);
    if ((hr && !sr) || (hwr && !swr)) return 16;
    if (w ? hwr : hr) return 1;
    if (w ? swr : sr) return 2;
    if (!sr) return 4;
    return 8;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (resp_valid !== exp_v || resp_class !== 5'(exp_cls) ||
        (exp_v && resp_frame !== FW'(exp_frm))) begin
      fails++;
      $display("FAIL %s: valid/class/frame = %0b/%0d/%0d, expected %0b/%0d/%0d",
               tag, resp_valid, resp_class, resp_frame, exp_v, exp_cls, exp_frm);
    end
  endtask

  // Drives one cycle at a falling edge; model computes from the pre-edge state
  task automatic step(input bit av, input int ap, input bit aw,
                      input bit dv, input int dp,
                      input bit iv, input int ip, input int is, input int ih,
                      input int ifr, input string tag);
    acc_valid = av; acc_page = PW'(ap); acc_write = aw;
    dem_valid = dv; dem_page = PW'(dp);
    inst_valid = iv; inst_page = PW'(ip); inst_soft = 2'(is);
    inst_hw = 2'(ih); inst_frame = FW'(ifr);
    exp_v = av;
    exp_cls = 0;
    if (av) begin
      exp_cls = ref_class(m_soft[ap], m_hw[ap], aw);
      exp_frm = m_frm[ap];
      if (exp_cls == 2) m_hw[ap] = m_soft[ap];
    end
    if (dv) m_hw[dp] = 0;
    if (iv) begin m_soft[ip] = is; m_hw[ip] = ih; m_frm[ip] = ifr; end
    @(negedge clk);
    check(tag);
  endtask

  task automatic rd(input int p, input string tag);
    step(1, p, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input int p, input string tag);
    step(1, p, 1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic dem(input int p, input string tag);
    step(0, 0, 0, 1, p, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ins(input int p, input int s, input int h, input int f, input string tag);
    step(0, 0, 0, 0, 0, 1, p, s, h, f, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int i = 0; i < NP; i++) begin m_soft[i] = 0; m_hw[i] = 0; m_frm[i] = 0; end
    exp_v = 0; exp_cls = 0; exp_frm = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset");
    for (int p = 0; p < NP; p++) rd(p, "R1 empty entry is hard");
    wr(3, "R5 hard fault on write");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 no request no response");

    ins(3, 2, 2, 8'h33, "R11 install");
    rd(3, "R3 marked read");
    wr(3, "R3 marked write");
    dem(3, "R8 demote");
    rd(3, "R4 unmarked read is soft");
    rd(3, "R4 repaired entry");
    wr(3, "R4 repaired to read-write");

    ins(5, 1, 1, 8'h55, "R11 install read-only");
    wr(5, "R7 write to read-only");
    rd(5, "R7 entry untouched");
    dem(5, "R8 demote read-only");
    wr(5, "R7 write to demoted read-only");
    rd(5, "R4 soft read after demote");
    rd(5, "R8 soft rights kept");

    ins(6, 2, 1, 8'h66, "R9 clean page");
    rd(6, "R9 read of clean page");
    wr(6, "R9 first write soft");
    wr(6, "R9 dirty page write");

    ins(7, 0, 1, 8'h77, "R6 install bad");
    rd(7, "R6 enforced without real");
    wr(7, "R6 enforced without real write");
    ins(8, 1, 2, 8'h88, "R6 install bad write");
    rd(8, "R6 enforced write beyond real");
    rd(8, "R6 entry unchanged");

    ins(9, 3, 3, 8'h99, "R12 code 11");
    wr(9, "R12 code 11 writes");
    ins(10, 3, 1, 8'hAA, "R12 code 11 clean");
    rd(10, "R12 read-only reads");
    wr(10, "R12 code 11 soft write");
    wr(10, "R12 repaired to 11");

    step(1, 3, 0, 1, 3, 0, 0, 0, 0, 0, "R10 access and demote marked");
    rd(3, "R10 demote applied after access");
    dem(3, "R10 demote");
    step(1, 3, 0, 1, 3, 0, 0, 0, 0, 0, "R10 soft with demote");
    rd(3, "R10 demote after repair");

    step(1, 11, 0, 0, 0, 1, 11, 2, 2, 8'hBB, "R11 access and install");
    rd(11, "R11 install visible");
    step(0, 0, 0, 1, 12, 1, 12, 2, 2, 8'hCC, "R11 install over demote");
    wr(12, "R11 install wins");
    step(1, 12, 1, 1, 12, 1, 12, 1, 0, 8'hC1, "R11 all three collide");
    rd(12, "R11 final contents");

    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[3:1]), lfsr[4],
           lfsr[5] & lfsr[6], int'(lfsr[9:7]),
           lfsr[10] & lfsr[11], int'(lfsr[14:12]),
           int'(lfsr[2:1]), int'(lfsr[8:7]), int'(lfsr[15:8]),
           "R2 mixed traffic");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 final idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule